// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is an up-counter built from a chain of identical narrow stages (four bits each by default) whose state registers all share one rising clock edge. Every stage offers a synchronous active-low clear, a synchronous active-low parallel load and two count enables. One enable, `cnt_en`, goes to every stage as its local enable. The other, `carry_en`, goes only to the lowest stage; each stage passes it on through a combinational carry output. Because of this chaining, the whole chain steps as one wide binary counter and needs no extra gating between stages.

The three controls have a fixed priority: clear wins over load, and load wins over counting. A designer can shorten the count sequence without any other logic by decoding a chosen terminal value and feeding the decoded result back to the clear input. The carry output of the top stage gives a full-count indication, and a wider counter outside this block can use it as its own enable.

Top module: `cnt_chain`

## Requirements
- R1: The count `q` changes only at a rising edge of `clk`. Pulses on `clr_n`, `ld_n`, `cnt_en`, `carry_en` or `din` that begin and end between two edges leave `q` unchanged both during the pulse and at the next edge.
- R2: When `clr_n` is 0 at a rising edge, `q` becomes 0 at that edge, whatever the values of `ld_n`, `cnt_en`, `carry_en` and `din`.
- R3: When `ld_n` is 0 and `clr_n` is 1 at a rising edge, `q` takes the value of `din` at that edge, whatever the values of the two enables.
- R4: When `clr_n` and `ld_n` are both 1, `q` increments by one at a rising edge only if `cnt_en` and `carry_en` are both 1. In every other case `q` holds its value.
- R5: When `q` is all ones and the block counts, `q` wraps to 0 at the next edge.
- R6: `carry_out` is 1 exactly when `q` is all ones and `carry_en` is 1, within the same cycle. `cnt_en` has no effect on it.
- R7: The chain behaves as one counter of STAGES*W bits. A stage steps only in the cycle in which every stage below it holds all ones, so a carry crosses a stage boundary at the same edge as the increment.
- R8: If `clr_n` is driven from a decode of `q` equal to a terminal value M, the count runs 0, 1, ..., M and then returns to 0 at the following edge.
- R9: While `rst_n` is 0, `q` is 0 at once, with no clock needed. After `rst_n` returns to 1, the first two rising edges leave `q` at 0, and the controls first take effect at the third rising edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| clr_n | input | 1 | Synchronous active-low clear, highest priority |
| ld_n | input | 1 | Synchronous active-low parallel load |
| cnt_en | input | 1 | Count enable shared by every stage; does not gate the carry |
| carry_en | input | 1 | Count enable of the lowest stage; also gates the carry chain |
| din | input | STAGES*W | Parallel load data |
| q | output | STAGES*W | Current count |
| carry_out | output | 1 | Full-count indication from the top stage |

## Verification
A result on `q` from clear, load or count appears at the first rising edge after the inputs that cause it. The bench drives inputs at a falling edge and holds them through the next rising edge. It then compares `q` at the falling edge that follows, before it changes any input. `carry_out` has no register in its path, so the bench checks it in that same half-cycle against the count it has just seen and the `carry_en` value it is still holding. After reset release, the bench checks `q` on each of the first three rising edges, because the two-flop release path delays the first update to the third edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Priority: clear over load over count.
  function automatic cnt_op_e decode_op(input logic clr_n,
                                        input logic ld_n,
                                        input logic step);
    cnt_op_e op;
    if (!clr_n)     op = OP_CLEAR;
    else if (!ld_n) op = OP_LOAD;
    else if (step)  op = OP_COUNT;
    else            op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_local,
  input  logic         en_chain,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_upd;
  cnt_op_e      op;

  // Next-state logic
  always_comb begin
    op      = decode_op(clr_n, ld_n, en_local && en_chain);
    cnt_d   = cnt_q;
    cnt_upd = 1'b0;
    unique case (op)
      OP_CLEAR: begin
        cnt_d   = '0;
        cnt_upd = 1'b1;
      end
      OP_LOAD: begin
        cnt_d   = din;
        cnt_upd = 1'b1;
      end
      OP_COUNT: begin
        cnt_d   = cnt_q + W'(1);
        cnt_upd = 1'b1;
      end
      default: begin
        cnt_d   = cnt_q;
        cnt_upd = 1'b0;
      end
    endcase
  end

  // State register with explicit clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q <= '0;
    end else if (cnt_upd) begin
      cnt_q <= cnt_d;
    end
  end

  assign q     = cnt_q;
  // Carry look-ahead: gated only by the chain enable, never by en_local
  assign carry = en_chain & (&cnt_q);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  ld_n,
  input  logic                  cnt_en,
  input  logic                  carry_en,
  input  logic [W*STAGES-1:0]   din,
  output logic [W*STAGES-1:0]   q,
  output logic                  carry_out
);

  localparam int TOTAL = W * STAGES;

  logic              rst_sync_n;
  logic [STAGES:0]   chain_en;
  logic [TOTAL-1:0]  q_all;

  cnt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign chain_en[0] = carry_en;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cnt_stage #(.W(W)) u_stage (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .clr_n      (clr_n),
      .ld_n       (ld_n),
      .en_local   (cnt_en),
      .en_chain   (chain_en[k]),
      .din        (din[k*W +: W]),
      .q          (q_all[k*W +: W]),
      .carry      (chain_en[k+1])
    );
  end

  assign q         = q_all;
  assign carry_out = chain_en[STAGES];

endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                clr_n,
  input logic                ld_n,
  input logic                cnt_en,
  input logic                carry_en,
  input logic [W*STAGES-1:0] din,
  input logic [W*STAGES-1:0] q,
  input logic                carry_out
);

  localparam int TOTAL = W * STAGES;

  // R9: internal reset holds the count at zero
  a_r9_reset_zero: assert property (@(posedge clk)
    !rst_sync_n |-> (q == '0));

  // R2
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clr_n |=> (q == '0));

  // R3
  a_r3_load_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && !ld_n) |=> (q == $past(din)));

  // R4 / R5: increment with natural wrap
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && ld_n && cnt_en && carry_en) |=> (q == TOTAL'($past(q) + 1'b1)));

  // R4 / R1: no step without both enables
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_n && ld_n && !(cnt_en && carry_en)) |=> $stable(q));

  // R6
  a_r6_carry_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((&q) && carry_en) |-> carry_out);

  a_r6_carry_clr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    carry_out |-> ((&q) && carry_en));

  // R7: upper stages move only when the low stage rolls over
  if (STAGES > 1) begin : g_upper
    a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (clr_n && ld_n && !(&q[W-1:0])) |=> $stable(q[TOTAL-1:W]));
  end

endmodule

bind cnt_chain cnt_chain_chk #(.W(W), .STAGES(STAGES)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .clr_n      (clr_n),
  .ld_n       (ld_n),
  .cnt_en     (cnt_en),
  .carry_en   (carry_en),
  .din        (din),
  .q          (q),
  .carry_out  (carry_out)
);

// File: tb/cnt_chain_tb_top.sv
module cnt_chain_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk;
  logic       rst_n;
  logic       clr_n;
  logic       ld_n;
  logic       cnt_en;
  logic       carry_en;
  logic [7:0] din;
  logic [7:0] q;
  logic       carry_out;

  int n_run;
  int n_fail;
  bit done;

  cnt_chain #(.W(4), .STAGES(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .ld_n      (ld_n),
    .cnt_en    (cnt_en),
    .carry_en  (carry_en),
    .din       (din),
    .q         (q),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {clr_n, ld_n, cnt_en, carry_en, din, expected q, expected carry_out}
  localparam int NV = 14;
  localparam logic [20:0] VECS [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},  // R3 load, enables low
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hA6, 1'b0},  // R4 count
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hA6, 1'b0},  // R4 carry_en low
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hA6, 1'b0},  // R4 cnt_en low
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hFE, 8'hFE, 1'b0},  // R3
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},  // R6 full count
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1},  // R6 cnt_en no effect
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0},  // R6 gated by carry_en
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R5 wrap
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h77, 8'h00, 1'b0},  // R2 clear beats load
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, 8'h0F, 1'b0},  // R3 load beats count
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0},  // R7 carry across stage
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},  // R2
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 1'b1}   // R3 / R6
  };
  localparam string VREQ [NV] = '{
    "R3", "R4", "R4", "R4", "R3", "R6", "R6",
    "R6", "R5", "R2", "R3", "R7", "R2", "R6"
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p,
                       input logic t, input logic [7:0] d);
    clr_n = c; ld_n = l; cnt_en = p; carry_en = t; din = d;
  endtask

  // called at a falling edge: apply, pass one rising edge, return at next falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("[TB] FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] ref_q;
    logic [7:0] prev;
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(q, 8'h00, "R9 reset state");
    check({7'd0, carry_out}, 8'h00, "R9 reset carry");

    // R9: release with a load pending; first update on third edge
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
    rst_n = 1'b1;
    cycle();
    check(q, 8'h00, "R9 edge 1 after release");
    cycle();
    check(q, 8'h00, "R9 edge 2 after release");
    cycle();
    check(q, 8'h5A, "R9 edge 3 after release");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][20], VECS[i][19], VECS[i][18], VECS[i][17], VECS[i][16:9]);
      cycle();
      check(q, VECS[i][8:1], VREQ[i]);
      check({7'd0, carry_out}, {7'd0, VECS[i][0]}, {VREQ[i], " carry"});
    end

    // R8: shortened modulus via clear decode of terminal value 5
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h00);
    cycle();
    check(q, 8'h00, "R8 start");
    prev = 8'h00;
    for (int i = 0; i < 14; i++) begin
      drive((q == 8'd5) ? 1'b0 : 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      cycle();
      check(q, (prev == 8'd5) ? 8'h00 : prev + 8'd1, "R8 modulus step");
      prev = q;
    end

    // R1: glitches between edges
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h30);
    cycle();
    drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    #0.4 ld_n = 1'b0; din = 8'hC3; clr_n = 1'b0; carry_en = 1'b1;
    #0.4 check(q, 8'h30, "R1 no change between edges");
    ld_n = 1'b1; clr_n = 1'b1; carry_en = 1'b0;
    cycle();
    check(q, 8'h30, "R1 pulse ignored at edge");

    // Reference-model run over pseudo-random controls (R2 R3 R4 R5 R6 R7)
    ref_q = q;
    for (int i = 0; i < 400; i++) begin
      logic c, l, p, t;
      logic [7:0] d;
      c = ($urandom_range(0, 15) != 0);
      l = ($urandom_range(0, 9) != 0);
      p = ($urandom_range(0, 5) != 0);
      t = ($urandom_range(0, 5) != 0);
      d = (($urandom_range(0, 3) == 0) ? 8'hFC : 8'($urandom_range(0, 255)));
      drive(c, l, p, t, d);
      if (!c)          ref_q = 8'h00;
      else if (!l)     ref_q = d;
      else if (p && t) ref_q = ref_q + 8'd1;
      cycle();
      check(q, ref_q, "R4 model (R2/R3/R5/R7)");
      check({7'd0, carry_out}, {7'd0, (&ref_q) & t}, "R6 model carry");
    end

    // R9: asynchronous reset mid-run
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h99);
    cycle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    #0.5 rst_n = 1'b0;
    #0.3 check(q, 8'h00, "R9 async clear without clock");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cycle();
    check(q, 8'h01, "R9 counting resumes on third edge");

    finish_run();
  end

endmodule